// File: doc/BRIEF.md
# MDIO Management Master

This block runs single management accesses to an external PHY over a two-wire management bus. It produces the management clock and a tri-state data line. A host loads a 32-bit control word, and an optional extension word, through plain write strobes. The control word holds the data, the register number, the direction, the clock divider code and the mode bits. The same word reads back with a busy flag and, once a read completes, the 16 data bits returned by the PHY.

Two frame styles are available. A direct frame carries a 5-bit register number taken from the control word. An extended access first sends an address frame that carries a 16-bit register address from the extension word, then sends a second frame that performs the read or the write. In background-poll mode the block keeps reading PHY register 1 whenever no commanded access is waiting. A command that arrives during a poll frame waits until that poll frame has ended.

Top module: `mdio_master`

## Requirements
- R1: Control word fields: data [15:0], register number [20:16], read select [21] (1 = read), preamble suppress [22], start [23], divider code [26:24], busy [27] (read-only), background poll enable [28], extended mode [30]. Bits 29 and 31 read as 0. Readback returns the stored fields with live busy and start.
- R2: The start bit reads back as 1 for exactly one cycle after a write that sets it. Busy rises on the cycle after that write and stays high until the access completes.
- R3: MDC idles high and toggles only while busy is high. MDIO changes while driven only when MDC falls.
- R4: Divider code 0 or 1 gives an MDC period of 4 reference clocks. Codes 2 to 7 give periods of 6, 8, 10, 32, 64 and 128 clocks.
- R5: A direct frame is sent MSB first: 32 ones of preamble (left out when suppress is set), start 01, opcode 10 for read or 01 for write, the PHY_ADDR parameter, the register number, turnaround 10 on a write, then 16 data bits.
- R6: On a read the master releases MDIO for both turnaround bits and the 16 data bits, samples MDIO on MDC rising edges, and places the value in [15:0] by the time busy falls.
- R7: Extension word: register address [15:0], device [20:16], port [25:21]. In extended mode the block sends an address frame (start 00, opcode 00, port, device, turnaround 10, address), then a frame with start 00, opcode 11 for read or 01 for write, port and device. The control word's register number is ignored.
- R8: With poll enabled and no command pending, the block repeatedly reads register POLL_REG (default 1) at PHY_ADDR, and each result lands in [15:0].
- R9: A command accepted during a poll frame starts only after that frame ends. The poll result does not overwrite the command's data.
- R10: Writes to the control or extension word are ignored while a commanded access is pending or running.
- R11: After reset the control readback is 0, MDC is high and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write value |
| ext_wr_i | input | 1 | Extension word write strobe |
| ext_wdata_i | input | 32 | Extension word write value |
| ctrl_rdata_o | output | 32 | Control word readback with status |
| mdio_i | input | 1 | MDIO line input |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO drive enable |

## Verification
The bench builds the block with PHY_ADDR set to 9 and keeps the default poll register of 1. A nonzero address exposes misplaced address bits that an all-zero address would hide. The bench sweeps all eight divider codes, so every period, including the folded code 1 and the slowest ratio of 128, is measured. With these settings an extended access and a poll-then-command overlap each finish in a few hundred clocks, so frame order, released turnaround bits and the guard on data overwrite can all be compared bit by bit against frames built arithmetically in the bench.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 64;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int HALF_W  = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_ADDR, ST_DATA} seq_state_e;

  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
    case (code)
      3'd2:    half_period = HALF_W'(3);
      3'd3:    half_period = HALF_W'(4);
      3'd4:    half_period = HALF_W'(5);
      3'd5:    half_period = HALF_W'(16);
      3'd6:    half_period = HALF_W'(32);
      3'd7:    half_period = HALF_W'(64);
      default: half_period = HALF_W'(2);
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] make_frame(
    input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa,
    input logic [4:0] ra, input logic [1:0] ta, input logic [DATA_W-1:0] d);
    make_frame = {{(FRAME_W/2){1'b1}}, st, op, pa, ra, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             mdc_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == half_i - CNT_W'(1));
  assign fall_o = wrap && mdc_q;
  assign rise_o = wrap && !mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int FRAME_W = 64,
  parameter int DATA_W  = 16,
  parameter int HALF_W  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               read_i,
  input  logic               nopre_i,
  input  logic [HALF_W-1:0]  half_i,
  input  logic               mdio_i,
  output logic               active_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic               active_q, done_q, rd_q, mdo_q, oe_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  cap_q;
  logic               fall, rise;

  mdio_clk_div #(.CNT_W(HALF_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active_q),
    .half_i(half_i),
    .mdc_o (mdc_o),
    .fall_o(fall),
    .rise_o(rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      mdo_q    <= 1'b1;
      oe_q     <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      cap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        frame_q  <= frame_i;
        rd_q     <= read_i;
        idx_q    <= nopre_i ? IDX_W'(FRAME_W/2 - 1) : IDX_W'(FRAME_W - 1);
      end else if (active_q) begin
        if (fall) begin
          mdo_q <= frame_q[idx_q];
          // release from first turnaround bit on reads
          oe_q  <= !(rd_q && idx_q <= IDX_W'(DATA_W + 1));
        end
        if (rise) begin
          if (rd_q && idx_q <= IDX_W'(DATA_W - 1))
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
          if (idx_q == '0) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q - IDX_W'(1);
          end
        end
      end else begin
        // hold last bit one clock past the final rising edge, then release
        oe_q  <= 1'b0;
        mdo_q <= 1'b1;
      end
    end
  end

  assign active_o  = active_q;
  assign done_o    = done_q;
  assign rdata_o   = cap_q;
  assign mdio_o    = mdo_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd0,
  parameter logic [4:0] POLL_REG = 5'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic [31:0] ctrl_wdata_i,
  input  logic        ext_wr_i,
  input  logic [31:0] ext_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [DATA_W-1:0]  data_q, xreg_q;
  logic [4:0]         reg_q, xdev_q, xport_q;
  logic [2:0]         clk_q;
  logic               rd_q, nopre_q, start_q, poll_q, ext_q, pend_q;
  logic               go_q, fread_q;
  logic [FRAME_W-1:0] frame_q;
  logic [HALF_W-1:0]  half_q;
  seq_state_e         state_q;

  logic               cmd_lock, busy, eng_done, eng_active;
  logic [DATA_W-1:0]  eng_rdata;
  logic               unused_ok;

  assign cmd_lock  = pend_q || state_q == ST_ADDR || state_q == ST_DATA;
  assign busy      = pend_q || state_q != ST_IDLE;
  assign unused_ok = ^{ctrl_wdata_i[31], ctrl_wdata_i[29], ctrl_wdata_i[27],
                       ext_wdata_i[31:26], eng_active};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      reg_q   <= '0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
      start_q <= 1'b0;
      clk_q   <= '0;
      poll_q  <= 1'b0;
      ext_q   <= 1'b0;
      pend_q  <= 1'b0;
      xreg_q  <= '0;
      xdev_q  <= '0;
      xport_q <= '0;
      go_q    <= 1'b0;
      fread_q <= 1'b0;
      frame_q <= '0;
      half_q  <= HALF_W'(2);
      state_q <= ST_IDLE;
    end else begin
      go_q    <= 1'b0;
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (pend_q) begin
            pend_q <= 1'b0;
            go_q   <= 1'b1;
            half_q <= half_period(clk_q);
            if (ext_q) begin
              frame_q <= make_frame(2'b00, 2'b00, xport_q, xdev_q, 2'b10, xreg_q);
              fread_q <= 1'b0;
              state_q <= ST_ADDR;
            end else begin
              frame_q <= make_frame(2'b01, rd_q ? 2'b10 : 2'b01, PHY_ADDR, reg_q,
                                    rd_q ? 2'b11 : 2'b10, data_q);
              fread_q <= rd_q;
              state_q <= ST_DATA;
            end
          end else if (poll_q) begin
            go_q    <= 1'b1;
            half_q  <= half_period(clk_q);
            frame_q <= make_frame(2'b01, 2'b10, PHY_ADDR, POLL_REG, 2'b11, '1);
            fread_q <= 1'b1;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (eng_done) begin
            if (!pend_q) data_q <= eng_rdata;
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (eng_done) begin
            go_q    <= 1'b1;
            frame_q <= make_frame(2'b00, rd_q ? 2'b11 : 2'b01, xport_q, xdev_q,
                                  rd_q ? 2'b11 : 2'b10, data_q);
            fread_q <= rd_q;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (eng_done) begin
            if (rd_q) data_q <= eng_rdata;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase

      if (ctrl_wr_i && !cmd_lock) begin
        data_q  <= ctrl_wdata_i[15:0];
        reg_q   <= ctrl_wdata_i[20:16];
        rd_q    <= ctrl_wdata_i[21];
        nopre_q <= ctrl_wdata_i[22];
        clk_q   <= ctrl_wdata_i[26:24];
        poll_q  <= ctrl_wdata_i[28];
        ext_q   <= ctrl_wdata_i[30];
        if (ctrl_wdata_i[23]) begin
          pend_q  <= 1'b1;
          start_q <= 1'b1;
        end
      end
      if (ext_wr_i && !cmd_lock) begin
        xreg_q  <= ext_wdata_i[15:0];
        xdev_q  <= ext_wdata_i[20:16];
        xport_q <= ext_wdata_i[25:21];
      end
    end
  end

  mdio_frame_engine #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go_q),
    .frame_i  (frame_q),
    .read_i   (fread_q),
    .nopre_i  (nopre_q),
    .half_i   (half_q),
    .mdio_i   (mdio_i),
    .active_o (eng_active),
    .done_o   (eng_done),
    .rdata_o  (eng_rdata),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

  assign ctrl_rdata_o = {1'b0, ext_q, 1'b0, poll_q, busy, clk_q, start_q,
                         nopre_q, rd_q, reg_q, data_q};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_wr_i,
  input logic        start_wr_i,
  input logic [31:0] ctrl_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  a_r3_idle_mdc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[27] |-> mdc_o);

  a_r3_mdc_moves_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdc_o) |-> ctrl_rdata_o[27]);

  a_r3_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o) && !$stable(mdio_o)) |-> $fell(mdc_o));

  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[23] |=> !ctrl_rdata_o[23]);

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && start_wr_i && !ctrl_rdata_o[27]) |=> ctrl_rdata_o[27]);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr_i),
  .start_wr_i  (ctrl_wdata_i[23]),
  .ctrl_rdata_o(ctrl_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PA = 5'd9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctrl_wr = 1'b0, ext_wr = 1'b0;
  logic [31:0] ctrl_wd = '0, ext_wd = '0;
  logic [31:0] ctrl_rd;
  logic        mdio_in = 1'b1, mdc, mdo, moe;

  int total = 0, bad = 0;
  int nb = 0, cyc = 0, last_rise = 0, per_last = 0, rc = 0;
  logic mdc_prev = 1'b1;
  logic lg_oe [0:199];
  logic lg_d  [0:199];
  logic [15:0] resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.PHY_ADDR(PA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wd),
    .ext_wr_i(ext_wr), .ext_wdata_i(ext_wd), .ctrl_rdata_o(ctrl_rd),
    .mdio_i(mdio_in), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe)
  );

  // bus observer and PHY responder
  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      if (nb < 200) begin
        lg_oe[nb] = moe;
        lg_d[nb]  = mdo;
      end
      nb++;
      per_last  = cyc - last_rise;
      last_rise = cyc;
    end
    if (!mdc && mdc_prev) begin
      if (moe) begin
        rc = 0;
        mdio_in = 1'b1;
      end else begin
        rc++;
        if (rc == 2) mdio_in = 1'b0;
        else if (rc >= 3 && rc <= 18) mdio_in = resp[18-rc];
        else mdio_in = 1'b1;
      end
    end
    mdc_prev = mdc;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [15:0] d, input logic [4:0] r,
    input logic rd, input logic np, input logic st, input logic [2:0] ck,
    input logic poll, input logic ext);
    cw = {1'b0, ext, 1'b0, poll, 1'b0, ck, st, np, rd, r, d};
  endfunction

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
    input logic [4:0] pa, input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] d);
    fr = {32'hFFFF_FFFF, st, op, pa, ra, ta, d};
  endfunction

  function automatic int period_of(input int code);
    case (code)
      2: period_of = 6;   3: period_of = 8;   4: period_of = 10;
      5: period_of = 32;  6: period_of = 64;  7: period_of = 128;
      default: period_of = 4;
    endcase
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_ext(input logic [31:0] v);
    @(negedge clk); ext_wr = 1'b1; ext_wd = v;
    @(negedge clk); ext_wr = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (ctrl_rd[27]);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input logic [63:0] f,
    input logic np, input logic rd, input int base);
    int n = np ? 32 : 64;
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      int idx = n - 1 - i;
      if (rd && idx <= 17) begin
        if (lg_oe[base+i] !== 1'b0) errs++;
      end else if (lg_oe[base+i] !== 1'b1 || lg_d[base+i] !== f[idx]) errs++;
    end
    check(req, errs, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ctrl", ctrl_rd, 32'h0);
    check("R11 mdc", {31'b0, mdc}, 1);
    check("R11 oe", {31'b0, moe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // direct write with preamble
    nb = 0;
    wr_ctrl(cw(16'hA5C3, 5'd5, 0, 0, 1, 3'd0, 0, 0));
    check("R2 start set", {31'b0, ctrl_rd[23]}, 1);
    check("R2 busy", {31'b0, ctrl_rd[27]}, 1);
    @(negedge clk);
    check("R2 start cleared", {31'b0, ctrl_rd[23]}, 0);
    wait_idle();
    check("R5 bit count", nb, 64);
    check_frame("R5 write frame", fr(2'b01, 2'b01, PA, 5'd5, 2'b10, 16'hA5C3), 0, 0, 0);
    check("R1 readback", ctrl_rd, 32'h0005_A5C3);
    check("R3 mdc idle", {31'b0, mdc}, 1);

    // direct read, preamble suppressed
    nb = 0; resp = 16'h1234;
    wr_ctrl(cw(16'h0, 5'd2, 1, 1, 1, 3'd0, 0, 0));
    wait_idle();
    check("R6 bit count", nb, 32);
    check_frame("R6 read frame", fr(2'b01, 2'b10, PA, 5'd2, 2'b11, 16'h0), 1, 1, 0);
    check("R6 read data", {16'h0, ctrl_rd[15:0]}, 32'h1234);

    // extended write, register field must be ignored
    wr_ext({6'b0, 5'd7, 5'd3, 16'hBEEF});
    nb = 0;
    wr_ctrl(cw(16'h55AA, 5'h1F, 0, 1, 1, 3'd0, 0, 1));
    wait_idle();
    check("R7 ext write count", nb, 64);
    check_frame("R7 ext addr frame", fr(2'b00, 2'b00, 5'd7, 5'd3, 2'b10, 16'hBEEF), 1, 0, 0);
    check_frame("R7 ext write frame", fr(2'b00, 2'b01, 5'd7, 5'd3, 2'b10, 16'h55AA), 1, 0, 32);

    // extended read with preamble
    nb = 0; resp = 16'hCAFE;
    wr_ctrl(cw(16'h0, 5'd0, 1, 0, 1, 3'd0, 0, 1));
    wait_idle();
    check("R7 ext read count", nb, 128);
    check_frame("R7 ext addr frame 2", fr(2'b00, 2'b00, 5'd7, 5'd3, 2'b10, 16'hBEEF), 0, 0, 0);
    check_frame("R7 ext read frame", fr(2'b00, 2'b11, 5'd7, 5'd3, 2'b11, 16'h0), 0, 1, 64);
    check("R7 ext read data", {16'h0, ctrl_rd[15:0]}, 32'hCAFE);

    // divider sweep
    for (int c = 0; c < 8; c++) begin
      nb = 0;
      wr_ctrl(cw(16'h00F0, 5'd4, 0, 1, 1, 3'(c), 0, 0));
      wait_idle();
      check($sformatf("R4 period code %0d", c), per_last, period_of(c));
      check($sformatf("R4 count code %0d", c), nb, 32);
    end

    // writes during a commanded access are dropped
    nb = 0;
    wr_ctrl(cw(16'h1111, 5'd4, 0, 1, 1, 3'd0, 0, 0));
    wr_ctrl(cw(16'h2222, 5'd8, 0, 1, 1, 3'd0, 0, 0));
    wr_ext({6'b0, 5'd2, 5'd2, 16'h0001});
    wait_idle();
    check("R10 single frame", nb, 32);
    check("R10 data kept", {16'h0, ctrl_rd[15:0]}, 32'h1111);
    check_frame("R10 frame", fr(2'b01, 2'b01, PA, 5'd4, 2'b10, 16'h1111), 1, 0, 0);
    nb = 0;
    wr_ctrl(cw(16'h0F0F, 5'd0, 0, 1, 1, 3'd0, 0, 1));
    wait_idle();
    check_frame("R10 ext word kept", fr(2'b00, 2'b00, 5'd7, 5'd3, 2'b10, 16'hBEEF), 1, 0, 0);

    // background poll, then a command arriving mid-frame
    nb = 0; resp = 16'h7788;
    wr_ctrl(cw(16'h0, 5'd0, 0, 1, 0, 3'd0, 1, 0));
    while (nb < 40) @(negedge clk);
    check("R8 poll data", {16'h0, ctrl_rd[15:0]}, 32'h7788);
    wr_ctrl(cw(16'h4321, 5'd6, 0, 1, 1, 3'd0, 0, 0));
    wait_idle();
    check("R9 frame count", nb, 96);
    check_frame("R8 poll frame 1", fr(2'b01, 2'b10, PA, 5'd1, 2'b11, 16'hFFFF), 1, 1, 0);
    check_frame("R9 poll frame 2", fr(2'b01, 2'b10, PA, 5'd1, 2'b11, 16'hFFFF), 1, 1, 32);
    check_frame("R9 command frame", fr(2'b01, 2'b01, PA, 5'd6, 2'b10, 16'h4321), 1, 0, 64);
    check("R9 data kept", {16'h0, ctrl_rd[15:0]}, 32'h4321);
    check("R3 mdc idle end", {31'b0, mdc}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule